// File: doc/BRIEF.md
# Strobe-and-Acknowledge Bus Cycle Sequencer

This block is the master side of a parallel bus on which each transfer is framed by an address strobe and closed by an active-low acknowledge from the slave. A local requester presents an address, write data, a direction bit and two byte-lane selects. When the sequencer accepts the request, it drives the bus through a fixed order of phases. It then waits as long as needed for the slave's acknowledge. At the end it returns a single-clock completion pulse and, for a read, the captured data.

The slave runs from a clock of the same frequency but of unknown phase. The acknowledge therefore goes through a synchronizer before the control logic sees it. The slave is allowed to acknowledge before its read data has settled, so read data is latched one clock after the acknowledge is recognised. On a write, the sequencer walks through three steps: address strobe, then the direction line, then the data drivers. The data strobes come last. This gives the slave a clean, ordered view of the cycle.

Top module: `busSeqMaster`

## Requirements
- R1: While reset is asserted and after it is released, the bus is idle: `addrStbN`, `upStbN` and `loStbN` are high, `rdWrN` is high, `busWdataOe` is low, `doneStb` is low and `reqReady` is high.
- R2: A request is accepted on a rising edge where `reqValid` and `reqReady` are both high. `busAddr` takes the request address at that edge. `addrStbN` goes low one full clock later. `busAddr` does not change while `addrStbN` is low.
- R3: On a read (`reqWrite`=0), the selected data strobes go low on the same edge as `addrStbN`. `rdWrN` stays high for the whole cycle and `busWdataOe` stays low.
- R4: On a write (`reqWrite`=1), `addrStbN` goes low first with `rdWrN` still high. One clock later `rdWrN` goes low. One clock after that `busWdataOe` rises. The selected data strobes go low one clock after that.
- R5: `upStbN` is driven only when the upper lane select was 1, and `loStbN` only when the lower lane select was 1. A request with both selects 0 is treated as a full-width transfer and strobes both lanes.
- R6: There is no limit on wait states. The acknowledge passes through two flops. Let k be the first rising edge at which `ackN` is sampled low. A write then enters its end phase at edge k+2. A read enters a capture phase at edge k+2 and its end phase at edge k+3. Until then all strobes stay asserted and `doneStb` stays low.
- R7: On a read, `rdData` takes the value on `busRdata` at the rising edge one clock after the acknowledge is recognised (edge k+3). It is valid while `doneStb` is high.
- R8: In the end phase all strobes are high, `rdWrN` is high, `busWdataOe` is low and `doneStb` is high for exactly one clock. `rdData` holds its value until the next read completes.
- R9: No new cycle starts until the synchronised acknowledge is negated. Let m be the last rising edge at which `ackN` is sampled low. `reqReady` stays low after edges up to and including m+1 and is high after edge m+2, so a stale acknowledge cannot end the next cycle.
- R10: While `busWdataOe` is high, `busWdata` equals the write data of the accepted request and does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Requester presents a transfer |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Transfer address |
| reqWdata | input | DATA_W | Write data |
| reqLaneHi | input | 1 | Upper byte lane select |
| reqLaneLo | input | 1 | Lower byte lane select |
| reqReady | output | 1 | Sequencer idle and acknowledge clear |
| doneStb | output | 1 | One-clock completion pulse |
| rdData | output | DATA_W | Captured read data |
| busAddr | output | ADDR_W | Bus address |
| addrStbN | output | 1 | Address strobe, active low |
| rdWrN | output | 1 | High = read, low = write |
| upStbN | output | 1 | Upper data strobe, active low |
| loStbN | output | 1 | Lower data strobe, active low |
| busWdata | output | DATA_W | Write data to bus |
| busWdataOe | output | 1 | Write data drive enable |
| busRdata | input | DATA_W | Read data from bus |
| ackN | input | 1 | Slave acknowledge, active low, unsynchronised |

## Verification
The slave model acknowledges after 0 to 20 clocks, and in one case after 150. This exposes a sequencer that caps its wait or counts the synchronizer latency wrongly: `doneStb` lands on the wrong clock. Read data is made valid up to three clocks after the acknowledge and is driven inverted before that. A design that latches on the recognition edge returns the inverted word. The slave sometimes holds the acknowledge low for many clocks after the strobes release. A design without the stale-acknowledge guard raises `reqReady` early and starts a cycle that the old acknowledge would end. Write cycles are traced clock by clock, so any swap in the order of strobe, direction, drive enable and data strobes shows up at once. Both lane selects at 0 checks the full-width default.

// File: rtl/busSeqPkg.sv
package busSeqPkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_ADDR    = 3'd1,
    ST_STROBE  = 3'd2,
    ST_WAIT    = 3'd3,
    ST_CAPTURE = 3'd4,
    ST_END     = 3'd5
  } seqState_t;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic loadReq;   // latch request fields
    logic asOn;      // address strobe asserted
    logic dsOn;      // data strobes asserted (lane-qualified in datapath)
    logic rwLow;     // direction line driven to write
    logic oeOn;      // write data drivers enabled
    logic capture;   // latch read data this edge
  } seqCtl_t;

endpackage

// File: rtl/busSeqCtrl.sv
module busSeqCtrl
  import busSeqPkg::*;
#(
  parameter int WR_RW_STEP = 1,
  parameter int WR_OE_STEP = 2
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    reqValid,
  input  logic    reqWrite,
  input  logic    ackSync,
  output logic    reqReady,
  output logic    doneStb,
  output seqCtl_t ctl
);

  localparam int STEP_W = $clog2(WR_OE_STEP + 1);
  localparam logic [STEP_W-1:0] RW_STEP = STEP_W'(WR_RW_STEP);
  localparam logic [STEP_W-1:0] OE_STEP = STEP_W'(WR_OE_STEP);

  seqState_t        state;
  seqState_t        nextState;
  logic [STEP_W-1:0] stepCnt;
  logic              isWrite;
  logic              accept;
  logic              lastStep;

  assign accept   = (state == ST_IDLE) && reqValid && !ackSync;
  assign lastStep = !isWrite || (stepCnt == OE_STEP);

  always_comb begin
    nextState = state;
    unique case (state)
      ST_IDLE:    if (accept) nextState = ST_ADDR;
      ST_ADDR:    nextState = ST_STROBE;
      ST_STROBE:  if (lastStep) nextState = ST_WAIT;
      ST_WAIT:    if (ackSync) nextState = isWrite ? ST_END : ST_CAPTURE;
      ST_CAPTURE: nextState = ST_END;
      ST_END:     nextState = ST_IDLE;
      default:    nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      isWrite <= 1'b0;
    end else begin
      state <= nextState;
      if (accept) isWrite <= reqWrite;
      if (state == ST_STROBE && !lastStep) stepCnt <= stepCnt + 1'b1;
      else if (state != ST_STROBE)         stepCnt <= '0;
    end
  end

  logic inStrobe, inBusy;
  assign inStrobe = (state == ST_STROBE);
  assign inBusy   = inStrobe || (state == ST_WAIT) || (state == ST_CAPTURE);

  always_comb begin
    ctl         = '0;
    ctl.loadReq = accept;
    ctl.asOn    = inBusy;
    ctl.dsOn    = isWrite ? (state == ST_WAIT) : inBusy;
    ctl.rwLow   = isWrite && ((inStrobe && stepCnt >= RW_STEP) || state == ST_WAIT);
    ctl.oeOn    = isWrite && ((inStrobe && stepCnt == OE_STEP) || state == ST_WAIT);
    ctl.capture = (state == ST_CAPTURE);
  end

  assign reqReady = (state == ST_IDLE) && !ackSync;
  assign doneStb  = (state == ST_END);

endmodule

// File: rtl/busSeqDatapath.sv
module busSeqDatapath
  import busSeqPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCtl_t           ctl,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqLaneHi,
  input  logic              reqLaneLo,
  input  logic              ackN,
  input  logic [DATA_W-1:0] busRdata,
  output logic              ackSync,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWdataOe,
  output logic              addrStbN,
  output logic              rdWrN,
  output logic              upStbN,
  output logic              loStbN,
  output logic [DATA_W-1:0] rdData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic              laneHiQ, laneLoQ;
  logic              noLane;
  logic [SYNC_STAGES-1:0] syncQ;

  assign noLane = !reqLaneHi && !reqLaneLo;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      wdataQ  <= '0;
      laneHiQ <= 1'b0;
      laneLoQ <= 1'b0;
    end else if (ctl.loadReq) begin
      addrQ   <= reqAddr;
      wdataQ  <= reqWdata;
      laneHiQ <= reqLaneHi || noLane;
      laneLoQ <= reqLaneLo || noLane;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            rdQ <= '0;
    else if (ctl.capture) rdQ <= busRdata;
  end

  // Acknowledge synchronizer, depth chosen by parameter.
  generate
    if (SYNC_STAGES > 1) begin : gSyncChain
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], ~ackN};
      end
    end else begin : gSyncSingle
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) syncQ <= '0;
        else       syncQ <= ~ackN;
      end
    end
  endgenerate

  assign ackSync    = syncQ[SYNC_STAGES-1];
  assign busAddr    = addrQ;
  assign busWdata   = wdataQ;
  assign busWdataOe = ctl.oeOn;
  assign addrStbN   = !ctl.asOn;
  assign rdWrN      = !ctl.rwLow;
  assign upStbN     = !(ctl.dsOn && laneHiQ);
  assign loStbN     = !(ctl.dsOn && laneLoQ);
  assign rdData     = rdQ;

endmodule

// File: rtl/busSeqMaster.sv
module busSeqMaster
  import busSeqPkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2,
  parameter int WR_RW_STEP  = 1,
  parameter int WR_OE_STEP  = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              reqLaneHi,
  input  logic              reqLaneLo,
  output logic              reqReady,
  output logic              doneStb,
  output logic [DATA_W-1:0] rdData,
  output logic [ADDR_W-1:0] busAddr,
  output logic              addrStbN,
  output logic              rdWrN,
  output logic              upStbN,
  output logic              loStbN,
  output logic [DATA_W-1:0] busWdata,
  output logic              busWdataOe,
  input  logic [DATA_W-1:0] busRdata,
  input  logic              ackN
);

  seqCtl_t ctl;
  logic    ackSync;

  busSeqCtrl #(
    .WR_RW_STEP (WR_RW_STEP),
    .WR_OE_STEP (WR_OE_STEP)
  ) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .reqWrite (reqWrite),
    .ackSync  (ackSync),
    .reqReady (reqReady),
    .doneStb  (doneStb),
    .ctl      (ctl)
  );

  busSeqDatapath #(
    .ADDR_W      (ADDR_W),
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .ctl        (ctl),
    .reqAddr    (reqAddr),
    .reqWdata   (reqWdata),
    .reqLaneHi  (reqLaneHi),
    .reqLaneLo  (reqLaneLo),
    .ackN       (ackN),
    .busRdata   (busRdata),
    .ackSync    (ackSync),
    .busAddr    (busAddr),
    .busWdata   (busWdata),
    .busWdataOe (busWdataOe),
    .addrStbN   (addrStbN),
    .rdWrN      (rdWrN),
    .upStbN     (upStbN),
    .loStbN     (loStbN),
    .rdData     (rdData)
  );

endmodule

// File: rtl/busSeqChk.sv
module busSeqChk #(
  parameter int ADDR_W = 24,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              doneStb,
  input logic [ADDR_W-1:0] busAddr,
  input logic              addrStbN,
  input logic              rdWrN,
  input logic              upStbN,
  input logic              loStbN,
  input logic [DATA_W-1:0] busWdata,
  input logic              busWdataOe
);

  // R2
  addr_setup_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(addrStbN) |-> $stable(busAddr));

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!addrStbN && $past(!addrStbN)) |-> $stable(busAddr));

  // R4
  rw_after_as_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(rdWrN) |-> $past(!addrStbN));

  // R4
  oe_after_rw_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busWdataOe) |-> $past(!rdWrN));

  // R4
  ds_after_oe_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdWrN && $fell(upStbN && loStbN)) |-> $past(busWdataOe));

  // R5
  ds_needs_as_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!upStbN || !loStbN) |-> !addrStbN);

  // R10
  oe_needs_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWdataOe |-> !rdWrN);

  // R10
  wdata_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWdataOe && $past(busWdataOe)) |-> $stable(busWdata));

  // R8
  end_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |-> (addrStbN && rdWrN && upStbN && loStbN && !busWdataOe));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneStb |=> !doneStb);

endmodule

bind busSeqMaster busSeqChk #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .doneStb    (doneStb),
  .busAddr    (busAddr),
  .addrStbN   (addrStbN),
  .rdWrN      (rdWrN),
  .upStbN     (upStbN),
  .loStbN     (loStbN),
  .busWdata   (busWdata),
  .busWdataOe (busWdataOe)
);

// File: tb/tb_busSeqMaster.sv
module tb_busSeqMaster;

  localparam int AW = 24;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0;
  logic          reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqLaneHi = 1'b0;
  logic          reqLaneLo = 1'b0;
  logic          reqReady, doneStb;
  logic [DW-1:0] rdData;
  logic [AW-1:0] busAddr;
  logic          addrStbN, rdWrN, upStbN, loStbN;
  logic [DW-1:0] busWdata;
  logic          busWdataOe;
  logic [DW-1:0] busRdata = '0;
  logic          ackN = 1'b1;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  int ackHighRun = 0;
  logic [DW-1:0] lastRd = '0;

  always #4 clk = ~clk;

  busSeqMaster dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqLaneHi(reqLaneHi),
    .reqLaneLo(reqLaneLo), .reqReady(reqReady), .doneStb(doneStb),
    .rdData(rdData), .busAddr(busAddr), .addrStbN(addrStbN), .rdWrN(rdWrN),
    .upStbN(upStbN), .loStbN(loStbN), .busWdata(busWdata),
    .busWdataOe(busWdataOe), .busRdata(busRdata), .ackN(ackN)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%h exp=%h t=%0t", req, what, act, exp, $time);
    end
  endtask

  // Count consecutive rising edges with the acknowledge negated.
  always @(posedge clk) ackHighRun <= ackN ? ackHighRun + 1 : 0;

  // Per-clock reference checks of the bus ordering rules.
  logic prevAsN = 1'b1;
  always @(negedge clk) begin
    if (rstN) begin
      chk(upStbN && loStbN || !addrStbN, "R5", "data strobe without address strobe",
          {30'd0, upStbN, loStbN}, 32'h3);
      chk(!busWdataOe || !rdWrN, "R10", "drive enable on read", {31'd0, rdWrN}, 32'd0);
      chk(rdWrN || !addrStbN, "R4", "write line outside strobe", {31'd0, addrStbN}, 32'd0);
      if (prevAsN && !addrStbN)
        chk(ackHighRun >= 4, "R9", "cycle started with stale acknowledge",
            ackHighRun, 32'd4);
      prevAsN <= addrStbN;
    end
  end

  task automatic xfer(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                      input bit hi, input bit lo, input int lat, input int skew,
                      input int hold);
    logic [DW-1:0] rv;
    bit expHi, expLo;
    int doneT;
    rv    = DW'($urandom);
    expHi = hi || (!hi && !lo);
    expLo = lo || (!hi && !lo);
    while (!reqReady) @(negedge clk);
    reqWrite = wr; reqAddr = a; reqWdata = wd; reqLaneHi = hi; reqLaneLo = lo;
    reqValid = 1'b1;
    @(negedge clk);
    reqValid = 1'b0;
    chk(addrStbN && busAddr == a, "R2", "address phase", {8'd0, busAddr}, {8'd0, a});
    @(negedge clk);
    chk(!addrStbN, "R2", "strobe one clock after address", {31'd0, addrStbN}, 32'd0);
    if (wr) begin
      chk(rdWrN && upStbN && loStbN && !busWdataOe, "R4", "write step0",
          {29'd0, rdWrN, upStbN & loStbN, busWdataOe}, 32'h6);
      @(negedge clk);
      chk(!rdWrN && upStbN && loStbN && !busWdataOe, "R4", "write step1",
          {29'd0, rdWrN, upStbN & loStbN, busWdataOe}, 32'h2);
      @(negedge clk);
      chk(!rdWrN && upStbN && loStbN && busWdataOe, "R4", "write step2",
          {29'd0, rdWrN, upStbN & loStbN, busWdataOe}, 32'h3);
      chk(busWdata == wd, "R10", "write data", {16'd0, busWdata}, {16'd0, wd});
      @(negedge clk);
    end else begin
      chk(rdWrN && !busWdataOe, "R3", "read direction", {30'd0, rdWrN, busWdataOe}, 32'h2);
    end
    chk(upStbN == !expHi && loStbN == !expLo, wr ? "R5" : "R3", "lane strobes",
        {30'd0, upStbN, loStbN}, {30'd0, !expHi, !expLo});
    doneT = wr ? lat + 3 : lat + 4;
    for (int t = 0; t <= doneT; t++) begin
      if (t > 0) @(negedge clk);
      if (t < doneT) begin
        chk(!doneStb && !addrStbN && busAddr == a, "R6", "waiting cycle",
            {30'd0, doneStb, addrStbN}, 32'd0);
        if (wr) chk(busWdataOe && busWdata == wd, "R10", "write data held",
                    {16'd0, busWdata}, {16'd0, wd});
      end else begin
        chk(doneStb && addrStbN && rdWrN && upStbN && loStbN && !busWdataOe, "R8",
            "end phase", {26'd0, doneStb, addrStbN, rdWrN, upStbN, loStbN, busWdataOe},
            32'h3E);
        if (wr) chk(rdData == lastRd, "R8", "read data kept over write",
                    {16'd0, rdData}, {16'd0, lastRd});
        else    chk(rdData == rv, "R7", "captured read data", {16'd0, rdData}, {16'd0, rv});
      end
      if (t == lat) ackN = 1'b0;
      if (!wr) busRdata = (t >= lat + skew) ? rv : ~rv;
    end
    if (!wr) lastRd = rv;
    for (int h = 0; h < hold; h++) begin
      @(negedge clk);
      chk(!doneStb && !reqReady, "R9", "ready held off by stale ack",
          {30'd0, doneStb, reqReady}, 32'd0);
    end
    ackN = 1'b1;
    @(negedge clk);
    chk(!doneStb, "R8", "single done pulse", {31'd0, doneStb}, 32'd0);
    chk(!reqReady, "R9", "ready one clock after ack release", {31'd0, reqReady}, 32'd0);
    @(negedge clk);
    chk(reqReady, "R9", "ready two clocks after ack release", {31'd0, reqReady}, 32'd1);
    chk(rdData == lastRd, "R8", "read data held", {16'd0, rdData}, {16'd0, lastRd});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(addrStbN && upStbN && loStbN && rdWrN && !busWdataOe && !doneStb, "R1",
        "outputs in reset", {26'd0, addrStbN, upStbN, loStbN, rdWrN, busWdataOe, doneStb},
        32'h3C);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk(addrStbN && upStbN && loStbN && rdWrN && !busWdataOe && !doneStb && reqReady,
        "R1", "idle after reset",
        {25'd0, addrStbN, upStbN, loStbN, rdWrN, busWdataOe, doneStb, reqReady}, 32'h79);
    xfer(1'b0, 24'h00_1234, 16'h0, 1'b1, 1'b1, 0, 3, 0);
    xfer(1'b1, 24'hAB_CDEF, 16'hBEEF, 1'b1, 1'b1, 0, 0, 0);
    xfer(1'b0, 24'h12_0000, 16'h0, 1'b0, 1'b0, 2, 1, 0);
    xfer(1'b1, 24'h00_0F0E, 16'h5A5A, 1'b1, 1'b0, 5, 0, 3);
    xfer(1'b0, 24'h00_0F0F, 16'h0, 1'b0, 1'b1, 20, 3, 0);
    xfer(1'b1, 24'h77_0001, 16'h1357, 1'b0, 1'b0, 1, 0, 10);
    xfer(1'b0, 24'h33_3333, 16'h0, 1'b1, 1'b1, 150, 2, 12);
    for (int i = 0; i < 60; i++) begin
      xfer(1'($urandom), AW'($urandom), DW'($urandom), 1'($urandom), 1'($urandom),
           int'($urandom_range(20, 0)), int'($urandom_range(3, 0)),
           int'($urandom_range(8, 0)));
    end
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=complete");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule